// File: doc/BRIEF.md
# Predicated Four-Way Deinterleaving Vector Loader

The block fills four destination vectors from memory that stores 8-bit values in groups of four. Group k holds element k of every destination: its lowest byte belongs to the first vector, the next byte to the second, and so on up to the fourth. A start pulse captures a scalar base address, a signed vector-count offset and a predicate mask with one bit per element. The block then walks the groups in ascending element order. It fetches each active group over a read port and leaves each inactive group at zero, without touching memory for it.

The memory side has two valid/ready channels. The request channel carries a byte address for one 4-byte group. The response channel returns the 32-bit group together with an error flag. The block keeps at most one request outstanding. It holds the request valid and address steady until the memory raises ready, and it raises response ready only while it waits for the data it asked for. A memory can therefore stall either channel for any number of cycles. Results are collected in a staging buffer and only move to the vector outputs when the whole operation completes. An error therefore aborts the operation without disturbing the vectors seen from outside. The vector length is a build parameter, from 128 to 2048 bits.

Top module: `quad_split_loader`

## Requirements
- R1: For an active element k, bits [8j+7:8j] of the response data for group k land in bits [8k+7:8k] of destination vector j, for j = 0 to 3.
- R2: For an element whose predicate bit (pred_i bit k) is 0, no request is issued for group k, and element k of all four vectors reads zero after completion.
- R3: Group k is requested at address base + vnum·4·(VLEN/8) + 4k. Here vnum is two's-complement and the sum wraps modulo 2^ADDR_W.
- R4: Requests for active groups are issued in ascending element order. No new request is issued until the response to the previous one has been accepted.
- R5: While the request valid is high and ready is low, the request valid stays high and the request address stays stable on the next cycle.
- R6: An error response for active element k ends the operation. fault_o pulses for one cycle with fault_idx_o = k, the four vectors keep their earlier values, and done_o does not pulse.
- R7: A successful operation ends with done_o high for exactly one cycle. The new vector contents are visible in that same cycle, and busy_o is already low.
- R8: A start pulse while busy_o is high is ignored. It causes no extra requests and no extra completion, and the running operation keeps its captured arguments.
- R9: After reset, all four vectors are zero and busy_o, done_o, fault_o and the request valid are low.
- R10: An error condition at the address of an inactive group never causes a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| base_addr_i | input | ADDR_W | Scalar base byte address |
| vnum_i | input | VNUM_W | Signed offset in whole-operation footprints |
| pred_i | input | VLEN/8 | Per-element predicate, bit k controls element k |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse on successful completion |
| fault_o | output | 1 | One-cycle pulse on an aborted operation |
| fault_idx_o | output | log2(VLEN/8) | Element index of the last fault |
| mreq_valid_o | output | 1 | Group read request valid |
| mreq_ready_i | input | 1 | Memory accepts the request |
| mreq_addr_o | output | ADDR_W | Byte address of the requested group |
| mrsp_valid_i | input | 1 | Response valid |
| mrsp_ready_o | output | 1 | Block accepts a response |
| mrsp_data_i | input | 32 | Four bytes of the group, byte j in bits [8j+7:8j] |
| mrsp_err_i | input | 1 | Response carries an error |
| vec0_o | output | VLEN | Destination vector 0 |
| vec1_o | output | VLEN | Destination vector 1 |
| vec2_o | output | VLEN | Destination vector 2 |
| vec3_o | output | VLEN | Destination vector 3 |

## Verification
Two pairs of events can share a single clock edge. The final data write into the staging buffer coincides with the commit of the whole buffer to the outputs. A stray start pulse can also arrive while a request is stalled or a response is pending. The bench provokes the first pair by making the last element active, so that its response is the commit cycle. It then compares all four vectors, including that element, in the cycle done_o rises. It provokes the second pair by pulsing start in the middle of an operation while a memory model inserts variable stalls on both channels. The scoreboard then finds that no unexpected request or completion appears, and that the addresses still follow the first operation's arguments.

// File: rtl/qsl_pkg.sv
package qsl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_REQ  = 2'd2,
    ST_RSP  = 2'd3
  } qsl_state_e;

  localparam int unsigned GROUP_BYTES = 4;
  localparam int unsigned NUM_DEST    = 4;
endpackage

// File: rtl/qsl_addr_gen.sv
module qsl_addr_gen #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned VNUM_W = 8,
  parameter int unsigned SHIFT  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [VNUM_W-1:0] vnum_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned EXT_W = ADDR_W - VNUM_W;

  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] cur_q;

  // signed vnum scaled by the byte footprint of one full operation
  assign offset = {{EXT_W{vnum_i[VNUM_W-1]}}, vnum_i} << SHIFT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_q <= '0;
    else if (load_i) cur_q <= base_i + offset;
    else if (step_i) cur_q <= cur_q + ADDR_W'(qsl_pkg::GROUP_BYTES);
  end

  assign addr_o = cur_q;

  p_addr_stride_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> (addr_o == $past(addr_o) + ADDR_W'(4)));
endmodule

// File: rtl/qsl_lane_buf.sv
module qsl_lane_buf #(
  parameter int unsigned VLEN  = 128,
  parameter int unsigned NELEM = VLEN / 8,
  parameter int unsigned IDX_W = $clog2(NELEM)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear_i,
  input  logic                  wr_en_i,
  input  logic [IDX_W-1:0]      wr_idx_i,
  input  logic [31:0]           wr_data_i,
  input  logic                  commit_i,
  output logic [3:0][VLEN-1:0]  vecs_o
);
  logic [3:0][VLEN-1:0] stage_q;
  logic [3:0][VLEN-1:0] stage_nx;
  logic [3:0][VLEN-1:0] vec_q;

  for (genvar j = 0; j < 4; j++) begin : g_dest
    for (genvar e = 0; e < NELEM; e++) begin : g_elem
      always_comb begin
        if (clear_i)
          stage_nx[j][e*8 +: 8] = 8'h00;
        else if (wr_en_i && (wr_idx_i == IDX_W'(e)))
          stage_nx[j][e*8 +: 8] = wr_data_i[j*8 +: 8];
        else
          stage_nx[j][e*8 +: 8] = stage_q[j][e*8 +: 8];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[j] <= '0;
        vec_q[j]   <= '0;
      end else begin
        stage_q[j] <= stage_nx[j];
        if (commit_i) vec_q[j] <= stage_nx[j];
      end
    end
  end

  assign vecs_o = vec_q;

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> $stable(vecs_o));
endmodule

// File: rtl/quad_split_loader.sv
module quad_split_loader #(
  parameter int unsigned VLEN   = 128,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned VNUM_W = 8,
  localparam int unsigned NELEM = VLEN / 8,
  localparam int unsigned IDX_W = $clog2(NELEM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [VNUM_W-1:0] vnum_i,
  input  logic [NELEM-1:0]  pred_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fault_o,
  output logic [IDX_W-1:0]  fault_idx_o,
  output logic              mreq_valid_o,
  input  logic              mreq_ready_i,
  output logic [ADDR_W-1:0] mreq_addr_o,
  input  logic              mrsp_valid_i,
  output logic              mrsp_ready_o,
  input  logic [31:0]       mrsp_data_i,
  input  logic              mrsp_err_i,
  output logic [VLEN-1:0]   vec0_o,
  output logic [VLEN-1:0]   vec1_o,
  output logic [VLEN-1:0]   vec2_o,
  output logic [VLEN-1:0]   vec3_o
);
  import qsl_pkg::*;

  localparam int unsigned SHIFT = $clog2(GROUP_BYTES * NELEM);

  qsl_state_e           state_q;
  logic [IDX_W-1:0]     idx_q;
  logic [NELEM-1:0]     pred_q;
  logic                 done_q, fault_q;
  logic [IDX_W-1:0]     fault_idx_q;
  logic                 last, active, load, step, rsp_take, wr_en, commit;
  logic [3:0][VLEN-1:0] vecs;

  assign last     = (idx_q == IDX_W'(NELEM - 1));
  assign active   = pred_q[idx_q];
  assign load     = (state_q == ST_IDLE) && start_i;
  assign rsp_take = (state_q == ST_RSP) && mrsp_valid_i;
  assign wr_en    = rsp_take && !mrsp_err_i;
  assign step     = ((state_q == ST_SCAN) && !active && !last) || (wr_en && !last);
  assign commit   = ((state_q == ST_SCAN) && !active && last) || (wr_en && last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      idx_q       <= '0;
      pred_q      <= '0;
      done_q      <= 1'b0;
      fault_q     <= 1'b0;
      fault_idx_q <= '0;
    end else begin
      done_q  <= commit;
      fault_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          pred_q  <= pred_i;
          idx_q   <= '0;
          state_q <= ST_SCAN;
        end
        ST_SCAN: begin
          if (active)     state_q <= ST_REQ;
          else if (last)  state_q <= ST_IDLE;
          else            idx_q   <= idx_q + 1'b1;
        end
        ST_REQ: if (mreq_ready_i) state_q <= ST_RSP;
        ST_RSP: if (mrsp_valid_i) begin
          if (mrsp_err_i) begin
            fault_q     <= 1'b1;
            fault_idx_q <= idx_q;
            state_q     <= ST_IDLE;
          end else if (last) begin
            state_q <= ST_IDLE;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= ST_SCAN;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  qsl_addr_gen #(.ADDR_W(ADDR_W), .VNUM_W(VNUM_W), .SHIFT(SHIFT)) u_addr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load),
    .step_i (step),
    .base_i (base_addr_i),
    .vnum_i (vnum_i),
    .addr_o (mreq_addr_o)
  );

  qsl_lane_buf #(.VLEN(VLEN), .NELEM(NELEM), .IDX_W(IDX_W)) u_lanes (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (load),
    .wr_en_i   (wr_en),
    .wr_idx_i  (idx_q),
    .wr_data_i (mrsp_data_i),
    .commit_i  (commit),
    .vecs_o    (vecs)
  );

  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = done_q;
  assign fault_o      = fault_q;
  assign fault_idx_o  = fault_idx_q;
  assign mreq_valid_o = (state_q == ST_REQ);
  assign mrsp_ready_o = (state_q == ST_RSP);
  assign vec0_o       = vecs[0];
  assign vec1_o       = vecs[1];
  assign vec2_o       = vecs[2];
  assign vec3_o       = vecs[3];

  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid_o && !mreq_ready_i) |=> (mreq_valid_o && $stable(mreq_addr_o)));
  p_active_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid_o |-> pred_q[idx_q]);
  p_rsp_after_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mrsp_ready_o) |-> $past(mreq_valid_o && mreq_ready_i));
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_fault_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (!done_o && $stable(vec0_o) && $stable(vec3_o)));
  p_ignore_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(pred_q));
endmodule

// File: tb/test_quad_split_loader.sv
module test_quad_split_loader;
  localparam int VL = 128;
  localparam int NE = VL / 8;

  typedef struct {
    bit                 is_fault;
    int                 idx;
    logic [3:0][VL-1:0] v;
    string              tag;
  } item_t;

  logic clk = 0, rst_n = 0;
  logic start = 0;
  logic [31:0] base = 0;
  logic [7:0]  vnum = 0;
  logic [NE-1:0] pred = 0;
  logic busy, done, fault;
  logic [3:0] fidx;
  logic mreq_valid, mreq_ready, mrsp_valid, mrsp_ready, mrsp_err;
  logic [31:0] mreq_addr, mrsp_data;
  logic [VL-1:0] v0, v1, v2, v3;

  int checks = 0, errors = 0, seed = 5;
  logic [31:0] bad_lo = 0, bad_hi = 0;
  logic [3:0][VL-1:0] last_vec = '0;
  item_t exp_q[$];
  logic [31:0] exp_addr[$];
  bit done_prev = 0;

  always #10 clk = ~clk;

  quad_split_loader #(.VLEN(VL), .ADDR_W(32), .VNUM_W(8)) i_quad_split_loader (
    .clk(clk), .rst_n(rst_n), .start_i(start), .base_addr_i(base), .vnum_i(vnum),
    .pred_i(pred), .busy_o(busy), .done_o(done), .fault_o(fault), .fault_idx_o(fidx),
    .mreq_valid_o(mreq_valid), .mreq_ready_i(mreq_ready), .mreq_addr_o(mreq_addr),
    .mrsp_valid_i(mrsp_valid), .mrsp_ready_o(mrsp_ready), .mrsp_data_i(mrsp_data),
    .mrsp_err_i(mrsp_err), .vec0_o(v0), .vec1_o(v1), .vec2_o(v2), .vec3_o(v3));

  function automatic logic [7:0] mbyte(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic bit is_bad(input logic [31:0] a);
    return (a >= bad_lo) && (a < bad_hi);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [VL-1:0] act, input logic [VL-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory model with variable stalls on both channels
  initial begin
    logic [31:0] a, e;
    mreq_ready = 0; mrsp_valid = 0; mrsp_data = 0; mrsp_err = 0;
    forever begin
      @(negedge clk);
      if (mreq_valid) begin
        seed = (seed * 13 + 7) % 101;
        repeat (seed % 3) @(negedge clk);
        a = mreq_addr;
        if (exp_addr.size() == 0) chk(0, "R2", "request not expected", a, 0);
        else begin
          e = exp_addr.pop_front();
          chk(a == e, "R3", "request address", a, e);
        end
        mreq_ready = 1;
        @(negedge clk);
        mreq_ready = 0;
        repeat (seed % 2) begin
          @(negedge clk);
          chk(!mreq_valid, "R4", "request while response pending", mreq_valid, 0);
        end
        mrsp_valid = 1;
        mrsp_err   = is_bad(a);
        for (int j = 0; j < 4; j++) mrsp_data[j*8 +: 8] = mbyte(a + 32'(j));
        @(negedge clk);
        mrsp_valid = 0;
        mrsp_err   = 0;
      end
    end
  end

  // scoreboard monitor
  initial begin
    item_t it;
    logic [3:0][VL-1:0] got;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (done_prev && done) chk(0, "R7", "done longer than one cycle", 1, 0);
        done_prev = done;
        if (done || fault) begin
          got = {v3, v2, v1, v0};
          if (exp_q.size() == 0) chk(0, "R8", "completion not expected", done, 0);
          else begin
            it = exp_q.pop_front();
            chk(fault == it.is_fault && done == !it.is_fault, it.is_fault ? "R6" : "R7",
                "completion kind (fault)", fault, it.is_fault);
            if (it.is_fault) chk(fidx == 4'(it.idx), "R6", "fault index", fidx, it.idx);
            for (int j = 0; j < 4; j++)
              chk(got[j] == it.v[j], it.tag, $sformatf("vector %0d", j), got[j], it.v[j]);
            chk(!busy, "R7", "busy low at completion", busy, 0);
          end
        end
      end
    end
  end

  // driver: predicts the outcome, then pulses start
  task automatic run_op(input logic [31:0] b, input int vn, input logic [NE-1:0] p,
                        input string tag, input bit poke);
    item_t it;
    logic [31:0] st, a;
    it.is_fault = 0; it.idx = 0; it.v = '0; it.tag = tag;
    st = b + 32'(vn * 4 * NE);
    for (int k = 0; k < NE; k++) begin
      if (p[k]) begin
        a = st + 32'(4 * k);
        exp_addr.push_back(a);
        if (is_bad(a)) begin
          it.is_fault = 1; it.idx = k;
          break;
        end
        for (int j = 0; j < 4; j++) it.v[j][k*8 +: 8] = mbyte(a + 32'(j));
      end
    end
    if (it.is_fault) it.v = last_vec;
    else last_vec = it.v;
    exp_q.push_back(it);
    @(negedge clk);
    base = b; vnum = 8'(vn); pred = p; start = 1;
    @(negedge clk);
    start = 0; base = 32'hDEAD_0000; vnum = 8'h11; pred = '1;
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1;
      @(negedge clk);
      start = 0;
    end
    while (exp_q.size() != 0) @(negedge clk);
    chk(exp_addr.size() == 0, "R2", "requests outstanding after completion", exp_addr.size(), 0);
    exp_addr.delete();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "R9", "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(v0 == 0 && v1 == 0 && v2 == 0 && v3 == 0, "R9", "vectors in reset", v0 | v3, 0);
    chk(!busy && !done && !fault && !mreq_valid, "R9", "control in reset",
        {busy, done, fault, mreq_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    // R1: all active, last element active -> commit shares cycle with final write
    run_op(32'h0000_1000, 0, '1, "R1", 0);
    // R2 / R3: alternate elements, negative offset
    run_op(32'h0000_2000, -2, 16'h5555, "R2", 0);
    // R10 sibling: every element inactive, no requests, all zero
    run_op(32'h0000_4000, 3, '0, "R2", 0);
    // R6: error on active element 5
    bad_lo = 32'h0000_3014; bad_hi = 32'h0000_3018;
    run_op(32'h0000_3000, 0, '1, "R6", 0);
    // R10: the same bad group is inactive -> clean completion
    run_op(32'h0000_3000, 0, 16'hFFDF, "R10", 0);
    bad_lo = 0; bad_hi = 0;
    // R8: stray start while busy
    run_op(32'h0000_5000, 1, 16'hF0F0, "R8", 1);
    // R3: largest positive offset with address wrap
    run_op(32'hFFFF_F000, 127, 16'h8001, "R3", 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule